// File: doc/BRIEF.md
# Vectored interrupt priority selector

This block sits beside the fetch logic of a small RISC-V-style core and decides, once per clock, which interrupt line (if any) should be serviced. It sees a non-maskable line, fifteen fast local lines and the external, timer and software lines. It masks the maskable ones with a global enable bit and a per-ID enable word, ranks the survivors by ID, and presents a request strobe, the winning ID and the vectored jump address. The vectored jump address is the vector-table base plus four times the ID. The non-maskable line ignores both enable controls. A debug-mode flag silences every interrupt, the non-maskable one included.

The block also turns an exception request into an exception strobe with an unvectored target, which is the vector base itself. It shows the levels of the maskable lines as a pending-bits word, and it forms the first fetch address from a boot address that it holds in a register. All outputs are registered and are recomputed every cycle from the current levels, so a request lasts exactly as long as its line stays high and its enables allow it. Writing control registers, flushing the pipeline and running the handler belong to the surrounding core.

Top module: `irq_vector_select`

## Requirements
- R1: `pend_view` shows the maskable line levels one cycle after they are sampled, with software at bit 3, timer at bit 7, external at bit 11 and fast line k at bit 16+k. Every other bit reads 0.
- R2: Bit 31 of `pend_view` is always 0, even while `nmi_line` is high.
- R3: A maskable line with ID n produces a request only when `glob_en` is 1 and `en_mask[n]` is 1 in the sampled cycle.
- R4: When several eligible lines are high, `irq_id` (5 bits) reports the highest ID. When `irq_req` is 0, both `irq_id` and `irq_target` are 0.
- R5: A high `nmi_line` gives `irq_req`=1 with `irq_id`=31, whatever the values of `glob_en` and `en_mask`.
- R6: `irq_target` equals the aligned base plus 4×`irq_id`. The aligned base is `vec_base` with its low 8 bits forced to 0, so the non-maskable line lands at aligned base + 0x7C.
- R7: `exc_req` gives `exc_taken`=1 one cycle later. `exc_target` always equals the aligned base, with no offset.
- R8: While `dbg_mode` is 1, `irq_req` is 0 one cycle later for every line, `nmi_line` included.
- R9: In a cycle where `exc_req` and an eligible interrupt are both present, only `exc_taken` is raised. The interrupt is requested in the first cycle after `exc_req` falls, as long as its line is still high.
- R10: Reset is synchronous and active high. One cycle after reset is sampled, `irq_req`, `irq_id`, `irq_target`, `exc_taken`, `exc_target` and `pend_view` are all 0.
- R11: `reset_fetch` equals the top 24 bits of the registered boot address followed by the byte 0x80. The boot address is sampled every cycle, during reset as well.
- R12: Lines are level-sensitive. A request stays up every cycle while its line is held high, and it drops in the cycle after the line falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_line | input | 1 | Non-maskable interrupt level (ID 31) |
| fast_lines | input | 15 | Fast local interrupt levels (IDs 16..30) |
| ext_line | input | 1 | External controller interrupt level (ID 11) |
| tmr_line | input | 1 | Timer interrupt level (ID 7) |
| sw_line | input | 1 | Software interrupt level (ID 3) |
| en_mask | input | 32 | Per-ID enable word, bit n enables ID n |
| glob_en | input | 1 | Global enable for maskable interrupts |
| vec_base | input | 32 | Vector-table base (low 8 bits ignored) |
| dbg_mode | input | 1 | Debug-mode flag, suppresses all interrupts |
| exc_req | input | 1 | Exception request |
| boot_addr | input | 32 | Boot address |
| pend_view | output | 32 | Pending-bits view of maskable lines |
| irq_req | output | 1 | Interrupt request strobe |
| irq_id | output | 5 | Selected interrupt ID |
| irq_target | output | 32 | Vectored interrupt jump address |
| exc_taken | output | 1 | Exception strobe |
| exc_target | output | 32 | Exception jump address |
| reset_fetch | output | 32 | First fetch address |

## Verification
An exception and an interrupt can land in the same cycle. The bench provokes this by holding a fast line and the non-maskable line high with every enable set, and then pulsing `exc_req` over several cycles, including a pulse while debug mode is also active. The result is judged against a behavioural per-cycle model: the exception strobe must rise, the interrupt strobe must stay low, and the interrupt must reappear in the first cycle after the exception request drops. Random traffic over thousands of cycles makes further overlaps of exceptions, debug mode and mixed pending lines.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int ID_W        = 5;
  localparam int ID_SPACE    = 1 << ID_W;
  localparam int NMI_ID      = 31;
  localparam int FAST_BASE   = 16;
  localparam int EXT_ID      = 11;
  localparam int TMR_ID      = 7;
  localparam int SW_ID       = 3;
  localparam int ALIGN_BITS  = 8;
  localparam logic [7:0] BOOT_LSB = 8'h80;

  typedef struct packed {
    logic            req;
    logic [ID_W-1:0] id;
  } pick_t;
endpackage

// File: rtl/irq_line_map.sv
module irq_line_map
  import irq_sel_pkg::*;
#(
  parameter int NUM_FAST = 15
) (
  input  logic                fast_lines_i [NUM_FAST],
  input  logic                ext_i,
  input  logic                tmr_i,
  input  logic                sw_i,
  output logic [ID_SPACE-1:0] raw_o
);
  for (genvar i = 0; i < ID_SPACE; i++) begin : g_slot
    if (i == SW_ID) begin : g_sw
      assign raw_o[i] = sw_i;
    end else if (i == TMR_ID) begin : g_tmr
      assign raw_o[i] = tmr_i;
    end else if (i == EXT_ID) begin : g_ext
      assign raw_o[i] = ext_i;
    end else if (i >= FAST_BASE && i < FAST_BASE + NUM_FAST && i != NMI_ID) begin : g_fast
      assign raw_o[i] = fast_lines_i[i-FAST_BASE];
    end else begin : g_zero
      assign raw_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W = 32,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_target_gen.sv
module irq_target_gen
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [XLEN-1:0] boot_i,
  output logic [XLEN-1:0] aligned_o,
  output logic [XLEN-1:0] vec_o,
  output logic [XLEN-1:0] boot_fetch_o
);
  localparam int SHIFT = 2;

  assign aligned_o    = {base_i[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign vec_o        = aligned_o + (XLEN'(id_i) << SHIFT);
  assign boot_fetch_o = {boot_i[XLEN-1:ALIGN_BITS], BOOT_LSB};
endmodule

// File: rtl/irq_vector_select.sv
module irq_vector_select
  import irq_sel_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_FAST = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nmi_line,
  input  logic [NUM_FAST-1:0] fast_lines,
  input  logic                ext_line,
  input  logic                tmr_line,
  input  logic                sw_line,
  input  logic [31:0]         en_mask,
  input  logic                glob_en,
  input  logic [XLEN-1:0]     vec_base,
  input  logic                dbg_mode,
  input  logic                exc_req,
  input  logic [XLEN-1:0]     boot_addr,
  output logic [31:0]         pend_view,
  output logic                irq_req,
  output logic [ID_W-1:0]     irq_id,
  output logic [XLEN-1:0]     irq_target,
  output logic                exc_taken,
  output logic [XLEN-1:0]     exc_target,
  output logic [XLEN-1:0]     reset_fetch
);
  logic                fast_arr [NUM_FAST];
  logic [ID_SPACE-1:0] raw_lines;
  logic [ID_SPACE-1:0] eligible;
  logic                any_mask;
  logic [ID_W-1:0]     mask_id;
  pick_t               pick;
  logic [XLEN-1:0]     aligned_base;
  logic [XLEN-1:0]     vec_addr;
  logic [XLEN-1:0]     boot_q;

  for (genvar k = 0; k < NUM_FAST; k++) begin : g_fast_arr
    assign fast_arr[k] = fast_lines[k];
  end

  irq_line_map #(.NUM_FAST(NUM_FAST)) u_map (
    .fast_lines_i (fast_arr),
    .ext_i        (ext_line),
    .tmr_i        (tmr_line),
    .sw_i         (sw_line),
    .raw_o        (raw_lines)
  );

  assign eligible = raw_lines & en_mask & {ID_SPACE{glob_en}};

  irq_prio_enc #(.W(ID_SPACE)) u_enc (
    .vec_i (eligible),
    .any_o (any_mask),
    .idx_o (mask_id)
  );

  always_comb begin
    pick = '0;
    if (!exc_req && !dbg_mode) begin
      if (nmi_line) begin
        pick.req = 1'b1;
        pick.id  = ID_W'(NMI_ID);
      end else if (any_mask) begin
        pick.req = 1'b1;
        pick.id  = mask_id;
      end
    end
  end

  irq_target_gen #(.XLEN(XLEN)) u_tgt (
    .base_i       (vec_base),
    .id_i         (pick.id),
    .boot_i       (boot_q),
    .aligned_o    (aligned_base),
    .vec_o        (vec_addr),
    .boot_fetch_o (reset_fetch)
  );

  always_ff @(posedge clk) begin
    boot_q <= boot_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_view  <= '0;
      irq_req    <= 1'b0;
      irq_id     <= '0;
      irq_target <= '0;
      exc_taken  <= 1'b0;
      exc_target <= '0;
    end else begin
      pend_view  <= raw_lines;
      irq_req    <= pick.req;
      irq_id     <= pick.id;
      irq_target <= pick.req ? vec_addr : '0;
      exc_taken  <= exc_req;
      exc_target <= aligned_base;
    end
  end

  // Maskable requests need both enables (R3)
  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_id != ID_W'(NMI_ID)) |->
      ($past(glob_en) && (($past(en_mask) & (32'd1 << irq_id)) != 32'd0)));

  // ID 31 only comes from the non-maskable line (R5)
  assert_nmi_source_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_id == ID_W'(NMI_ID)) |-> $past(nmi_line));

  // Vectored target relative to the exception target (R6)
  assert_vec_offset_R6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_target == exc_target + (XLEN'(irq_id) << 2)));

  // Debug mode silences everything (R8)
  assert_dbg_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(dbg_mode) |-> !irq_req);

  // Exception wins over a simultaneous interrupt (R9)
  assert_exc_first_R9: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> !irq_req);

  // Idle ID and target are zero (R4)
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_id == '0 && irq_target == '0));
endmodule

// File: tb/irq_vector_select_bench.sv
module irq_vector_select_bench;
  localparam int PERIOD = 10;
  localparam int NF = 15;

  logic        clk = 1'b0;
  logic        rst;
  logic        nmi_line;
  logic [NF-1:0] fast_lines;
  logic        ext_line, tmr_line, sw_line;
  logic [31:0] en_mask;
  logic        glob_en;
  logic [31:0] vec_base;
  logic        dbg_mode;
  logic        exc_req;
  logic [31:0] boot_addr;
  logic [31:0] pend_view;
  logic        irq_req;
  logic [4:0]  irq_id;
  logic [31:0] irq_target;
  logic        exc_taken;
  logic [31:0] exc_target;
  logic [31:0] reset_fetch;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string phase = "R10";

  logic [31:0] e_pend, e_tgt, e_exct, e_fetch;
  logic        e_req, e_exc;
  logic [4:0]  e_id;

  always #(PERIOD/2) clk = ~clk;

  irq_vector_select u_irq_vector_select (
    .clk(clk), .rst(rst), .nmi_line(nmi_line), .fast_lines(fast_lines),
    .ext_line(ext_line), .tmr_line(tmr_line), .sw_line(sw_line),
    .en_mask(en_mask), .glob_en(glob_en), .vec_base(vec_base),
    .dbg_mode(dbg_mode), .exc_req(exc_req), .boot_addr(boot_addr),
    .pend_view(pend_view), .irq_req(irq_req), .irq_id(irq_id),
    .irq_target(irq_target), .exc_taken(exc_taken),
    .exc_target(exc_target), .reset_fetch(reset_fetch)
  );

  task automatic model();
    e_fetch = {boot_addr[31:8], 8'h80};
    e_pend = '0; e_req = 0; e_id = '0; e_tgt = '0; e_exc = 0; e_exct = '0;
    if (!rst) begin
      e_pend[3] = sw_line; e_pend[7] = tmr_line; e_pend[11] = ext_line;
      for (int k = 0; k < NF; k++) e_pend[16+k] = fast_lines[k];
      e_exct = {vec_base[31:8], 8'h00};
      e_exc = exc_req;
      if (!exc_req && !dbg_mode) begin
        if (nmi_line) begin
          e_req = 1; e_id = 5'd31;
        end else if (glob_en) begin
          for (int i = 30; i >= 0; i--) begin
            if (!e_req && e_pend[i] && en_mask[i]) begin
              e_req = 1; e_id = 5'(i);
            end
          end
        end
      end
      if (e_req) e_tgt = e_exct + 32'(e_id) * 4;
    end
  endtask

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic cyc();
    model();
    @(posedge clk);
    @(negedge clk);
    cmp("pend_view(R1)", pend_view, e_pend);
    cmp("irq_req", 32'(irq_req), 32'(e_req));
    cmp("irq_id(R4)", 32'(irq_id), 32'(e_id));
    cmp("irq_target(R6)", irq_target, e_tgt);
    cmp("exc_taken(R7)", 32'(exc_taken), 32'(e_exc));
    cmp("exc_target(R7)", exc_target, e_exct);
    cmp("reset_fetch(R11)", reset_fetch, e_fetch);
  endtask

  task automatic quiet();
    nmi_line = 0; fast_lines = '0; ext_line = 0; tmr_line = 0; sw_line = 0;
    dbg_mode = 0; exc_req = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1; quiet();
    en_mask = '1; glob_en = 1; vec_base = 32'h2000_1234; boot_addr = 32'h0000_5a5a;
    nmi_line = 1; sw_line = 1; exc_req = 1;
    @(negedge clk);
    phase = "R10"; cyc(); cyc();
    phase = "R11"; boot_addr = 32'hdead_beef; cyc(); boot_addr = 32'h1234_56ff; cyc();
    rst = 0; quiet(); en_mask = '0; glob_en = 0;
    // R1: each line alone, nothing enabled
    phase = "R1";
    sw_line = 1; cyc(); sw_line = 0; tmr_line = 1; cyc(); tmr_line = 0;
    ext_line = 1; cyc(); ext_line = 0;
    for (int k = 0; k < NF; k++) begin fast_lines = '0; fast_lines[k] = 1; cyc(); end
    fast_lines = '0;
    // R3: enable combinations
    phase = "R3";
    tmr_line = 1; glob_en = 1; en_mask = 32'h0; cyc();
    glob_en = 0; en_mask = 32'h80; cyc();
    glob_en = 1; cyc();
    en_mask = 32'hffff_ff7f; cyc();
    tmr_line = 0;
    // R4: several pending, highest wins
    phase = "R4";
    en_mask = '1; glob_en = 1; sw_line = 1; tmr_line = 1; ext_line = 1; cyc();
    fast_lines = 15'h0005; cyc();
    fast_lines = 15'h4001; cyc();
    en_mask = 32'hbfff_ffff; cyc();
    quiet(); cyc();
    // R5 / R2: NMI ignores enables, hidden from pend_view
    phase = "R5"; glob_en = 0; en_mask = '0; nmi_line = 1; fast_lines = 15'h7fff; cyc();
    phase = "R2"; glob_en = 1; en_mask = '1; cyc();
    // R6: unaligned base bits are dropped
    phase = "R6"; vec_base = 32'hffff_ffff; cyc();
    nmi_line = 0; fast_lines = '0; ext_line = 1; vec_base = 32'h0000_00c4; cyc();
    ext_line = 0;
    // R7: exception alone
    phase = "R7"; exc_req = 1; vec_base = 32'h8000_07ab; cyc(); exc_req = 0; cyc();
    // R8: debug suppresses all, NMI included
    phase = "R8"; dbg_mode = 1; nmi_line = 1; fast_lines = 15'h1; sw_line = 1; cyc(); cyc();
    dbg_mode = 0; cyc();
    // R9: exception and interrupt together
    phase = "R9"; exc_req = 1; cyc(); exc_req = 0; cyc();
    nmi_line = 0; exc_req = 1; cyc(); cyc(); exc_req = 0; cyc();
    dbg_mode = 1; exc_req = 1; cyc(); dbg_mode = 0; exc_req = 0; cyc();
    // R12: level behaviour
    phase = "R12"; quiet(); tmr_line = 1; cyc(); cyc(); cyc(); tmr_line = 0; cyc(); cyc();
    // R4: random traffic
    phase = "R4";
    for (int n = 0; n < 3000; n++) begin
      nmi_line   = ($urandom_range(0, 7) == 0);
      fast_lines = NF'($urandom) & NF'($urandom);
      ext_line   = 1'($urandom); tmr_line = 1'($urandom); sw_line = 1'($urandom);
      en_mask    = $urandom;
      glob_en    = ($urandom_range(0, 3) != 0);
      dbg_mode   = ($urandom_range(0, 7) == 0);
      exc_req    = ($urandom_range(0, 5) == 0);
      vec_base   = $urandom;
      boot_addr  = $urandom;
      rst        = ($urandom_range(0, 99) == 0);
      cyc();
    end
    rst = 0; quiet(); cyc();
    summary();
  end
endmodule